// File: doc/BRIEF.md
# Length-Framed Packet Framer

This block turns buffered payload bytes into a framed byte stream for a radio link, and turns a received byte stream back into payload. A transmitted data packet is a preamble, a two-byte start marker, one length byte, the payload and a 16-bit check field. The block can also send a short acknowledge packet: preamble, start marker and a 16-bit check value handed in by the host, with no length byte. Spreading, modulation and bit timing sit outside; the physical side is seen as a stream of whole bytes.

Each direction has a small byte buffer (16 bytes by default), while packets may carry up to 255 payload bytes. The host therefore refills the transmit buffer and drains the receive buffer while a packet is in flight, guided by the empty, half and overflow/underflow flags. On receive, the block hunts for the start marker (or, with framing off, for two successive correlation hits), takes the length, counts payload bytes into the buffer and ends the packet after the length count plus two check bytes. The check is accepted against either the configured seed or a zero seed.

Top module: `pkt_framer`

## Requirements
- R1: After reset, tx_valid, rx_eop, rx_err, rx_crc_ok and rx_overflow are 0, and tx_empty, tx_half and rx_empty are 1.
- R2: A tx_go sends PRE_CNT bytes of PREAMBLE, then MARK0, MARK1, the tx_len byte, tx_len payload bytes in the order they were written, the check high byte, the check low byte; tx_done pulses for one cycle after the last byte is taken, and tx_valid is then 0.
- R3: The check is CRC-16 with polynomial 0x8005, processed MSB first per byte, no final inversion, run over the length byte and the payload; the transmit seed is crc_seed, or 0 when tx_seed_zero is 1 at tx_go.
- R4: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data does not change (unless the payload byte is a pad, see R7); a byte is taken on each edge where both are 1.
- R5: An ack_go sends PRE_CNT preamble bytes, MARK0, MARK1, ack_crc[15:8], ack_crc[7:0]; the transmit buffer contents are left untouched.
- R6: tx_go and ack_go are ignored while a packet is being sent; when both are high in an idle cycle, the data packet is sent.
- R7: The transmit buffer holds DEPTH bytes; tx_empty shows zero bytes held and tx_half shows at most DEPTH/2 held; a write while full is dropped and pulses tx_overflow; a payload byte needed while the buffer is empty is sent as 0x00 and pulses tx_underflow; writes during a packet extend the payload.
- R8: With rx_framing_en at 1, a packet starts on a valid MARK0 byte followed by a valid MARK1 byte; a repeated MARK0 keeps waiting for MARK1, any other byte restarts the hunt.
- R9: With rx_framing_en at 0, a packet starts after two successive valid bytes with rx_in_corr at 1; a valid byte without it in between restarts the hunt.
- R10: The first byte after the start is shown on rx_len; rx_eop pulses for one cycle in the cycle after the last of rx_len plus two further bytes is taken, also for length 0.
- R11: The received check (first byte high) is compared with the CRC of R3 under crc_seed and under a zero seed; rx_crc_ok is 1 if either matches, rx_pkt_crc holds the received value, both updated with rx_eop.
- R12: A payload byte arriving while the receive buffer holds DEPTH bytes is dropped and sets rx_overflow until the next start; rx_err at rx_eop is 1 on a check mismatch or an overflow.
- R13: rx_rd_data shows the oldest held byte; rx_rd_en removes it; a read while empty pulses rx_underflow; rx_empty and rx_half (at least DEPTH/2 held) follow the count; draining during a packet avoids overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crc_seed | input | 16 | Configured check seed |
| tx_wr_en | input | 1 | Write one byte into the transmit buffer |
| tx_wr_data | input | 8 | Byte to write |
| tx_len | input | 8 | Payload length, taken at tx_go |
| tx_seed_zero | input | 1 | Use a zero seed for the transmitted check |
| tx_go | input | 1 | Start a data packet |
| ack_go | input | 1 | Start an acknowledge packet |
| ack_crc | input | 16 | Check value sent in the acknowledge packet |
| tx_ready | input | 1 | Physical side takes the current byte |
| tx_valid | output | 1 | A byte is offered on tx_data |
| tx_data | output | 8 | Outgoing byte |
| tx_done | output | 1 | Pulse after the last byte of a packet |
| tx_empty | output | 1 | Transmit buffer empty |
| tx_half | output | 1 | Transmit buffer at most half full |
| tx_overflow | output | 1 | Pulse: write to a full buffer dropped |
| tx_underflow | output | 1 | Pulse: pad byte sent from an empty buffer |
| rx_framing_en | input | 1 | 1: marker bytes start a packet; 0: correlation hits do |
| rx_in_valid | input | 1 | Incoming byte valid |
| rx_in_data | input | 8 | Incoming byte |
| rx_in_corr | input | 1 | Incoming byte came with a correlation hit |
| rx_rd_en | input | 1 | Remove the oldest received byte |
| rx_rd_data | output | 8 | Oldest received byte |
| rx_len | output | 8 | Length of the current or last packet |
| rx_eop | output | 1 | Pulse at end of packet |
| rx_crc_ok | output | 1 | Last packet's check matched |
| rx_err | output | 1 | Last packet had a check mismatch or overflow |
| rx_pkt_crc | output | 16 | Check field of the last packet |
| rx_empty | output | 1 | Receive buffer empty |
| rx_half | output | 1 | Receive buffer at least half full |
| rx_overflow | output | 1 | Payload byte dropped in the current packet |
| rx_underflow | output | 1 | Pulse: read from an empty buffer |

## Verification
Transmit packets are sent with short, zero, full-buffer and longer-than-buffer lengths, with and without back-pressure on tx_ready, and with both seeds, which separates ordering faults, check faults and refill faults. A starved buffer shows whether pad bytes still enter the check, and an acknowledge sent over a loaded buffer shows it leaves the payload alone. Received packets arrive with the configured seed, the zero seed and a corrupted check, with framing on and off, behind a repeated marker, a broken marker and a lone correlation hit, which tells start-detection faults from counting faults. A long packet that is not drained and one that is drained while it arrives separate the overflow path from the normal buffer path.

// File: rtl/pkt_framer.sv
`timescale 1ns/1ps
module pkt_framer #(
  parameter int         DEPTH    = 16,
  parameter int         PRE_CNT  = 2,
  parameter logic [7:0] PREAMBLE = 8'h55,
  parameter logic [7:0] MARK0    = 8'hB4,
  parameter logic [7:0] MARK1    = 8'h2D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] crc_seed,
  input  logic        tx_wr_en,
  input  logic [7:0]  tx_wr_data,
  input  logic [7:0]  tx_len,
  input  logic        tx_seed_zero,
  input  logic        tx_go,
  input  logic        ack_go,
  input  logic [15:0] ack_crc,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_done,
  output logic        tx_empty,
  output logic        tx_half,
  output logic        tx_overflow,
  output logic        tx_underflow,
  input  logic        rx_framing_en,
  input  logic        rx_in_valid,
  input  logic [7:0]  rx_in_data,
  input  logic        rx_in_corr,
  input  logic        rx_rd_en,
  output logic [7:0]  rx_rd_data,
  output logic [7:0]  rx_len,
  output logic        rx_eop,
  output logic        rx_crc_ok,
  output logic        rx_err,
  output logic [15:0] rx_pkt_crc,
  output logic        rx_empty,
  output logic        rx_half,
  output logic        rx_overflow,
  output logic        rx_underflow
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int NW = $clog2(PRE_CNT + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [NW-1:0] PRE_LAST = NW'(PRE_CNT - 1);

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? 16'h8005 : 16'h0000);
    return r;
  endfunction

  typedef enum logic [2:0] {T_IDLE, T_PRE, T_M0, T_M1, T_LEN, T_PAY, T_CH, T_CL} tx_st_t;
  typedef enum logic [2:0] {R_HUNT, R_M1, R_LEN, R_PAY, R_C1, R_C2} rx_st_t;

  tx_st_t          tx_st;
  logic            tx_ack;
  logic [NW-1:0]   tx_pre;
  logic [7:0]      tx_left, tx_lenq;
  logic [15:0]     tx_crc;
  logic [7:0]      tx_mem [DEPTH];
  logic [PW-1:0]   tx_wp, tx_rp;
  logic [CW-1:0]   tx_cnt;

  logic            tx_fire, tx_pop, tx_push;
  assign tx_valid = (tx_st != T_IDLE);
  assign tx_fire  = tx_valid && tx_ready;
  assign tx_pop   = tx_fire && (tx_st == T_PAY) && (tx_cnt != '0);
  assign tx_push  = tx_wr_en && (tx_cnt != FULL);
  assign tx_empty = (tx_cnt == '0);
  assign tx_half  = (tx_cnt <= HALF);

  always_comb begin
    case (tx_st)
      T_PRE:   tx_data = PREAMBLE;
      T_M0:    tx_data = MARK0;
      T_M1:    tx_data = MARK1;
      T_LEN:   tx_data = tx_lenq;
      T_PAY:   tx_data = tx_empty ? 8'h00 : tx_mem[tx_rp];
      T_CH:    tx_data = tx_crc[15:8];
      T_CL:    tx_data = tx_crc[7:0];
      default: tx_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st   <= T_IDLE;
      tx_ack  <= 1'b0;
      tx_pre  <= '0;
      tx_left <= '0;
      tx_lenq <= '0;
      tx_crc  <= '0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (tx_st == T_IDLE) begin
        tx_pre <= '0;
        if (tx_go) begin
          tx_st   <= T_PRE;
          tx_ack  <= 1'b0;
          tx_lenq <= tx_len;
          tx_left <= tx_len;
          tx_crc  <= tx_seed_zero ? 16'h0000 : crc_seed;
        end else if (ack_go) begin
          tx_st  <= T_PRE;
          tx_ack <= 1'b1;
          tx_crc <= ack_crc;
        end
      end else if (tx_ready) begin
        case (tx_st)
          T_PRE: begin
            tx_pre <= tx_pre + 1'b1;
            if (tx_pre == PRE_LAST) tx_st <= T_M0;
          end
          T_M0: tx_st <= T_M1;
          T_M1: tx_st <= tx_ack ? T_CH : T_LEN;
          T_LEN: begin
            tx_crc <= crc_step(tx_crc, tx_lenq);
            tx_st  <= (tx_lenq == 8'd0) ? T_CH : T_PAY;
          end
          T_PAY: begin
            tx_crc  <= crc_step(tx_crc, tx_data);
            tx_left <= tx_left - 1'b1;
            if (tx_left == 8'd1) tx_st <= T_CH;
          end
          T_CH: tx_st <= T_CL;
          T_CL: begin
            tx_st   <= T_IDLE;
            tx_done <= 1'b1;
          end
          default: tx_st <= T_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp        <= '0;
      tx_rp        <= '0;
      tx_cnt       <= '0;
      tx_overflow  <= 1'b0;
      tx_underflow <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt       <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      tx_overflow  <= tx_wr_en && !tx_push;
      tx_underflow <= tx_fire && (tx_st == T_PAY) && tx_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wr_data;
  end

  rx_st_t          rx_st;
  logic [7:0]      rx_left, rx_hi;
  logic [15:0]     crc_a, crc_z;
  logic [7:0]      rx_mem [DEPTH];
  logic [PW-1:0]   rx_wp, rx_rp;
  logic [CW-1:0]   rx_cnt;

  logic            hit0, hit1, rx_push, rx_pop, rx_match;
  logic [15:0]     rx_got;
  assign hit0     = rx_framing_en ? (rx_in_data == MARK0) : rx_in_corr;
  assign hit1     = rx_framing_en ? (rx_in_data == MARK1) : rx_in_corr;
  assign rx_push  = rx_in_valid && (rx_st == R_PAY) && (rx_cnt != FULL);
  assign rx_pop   = rx_rd_en && (rx_cnt != '0);
  assign rx_empty = (rx_cnt == '0);
  assign rx_half  = (rx_cnt >= HALF);
  assign rx_rd_data = rx_mem[rx_rp];
  assign rx_got   = {rx_hi, rx_in_data};
  assign rx_match = (rx_got == crc_a) || (rx_got == crc_z);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st       <= R_HUNT;
      rx_left     <= '0;
      rx_hi       <= '0;
      crc_a       <= '0;
      crc_z       <= '0;
      rx_len      <= '0;
      rx_eop      <= 1'b0;
      rx_crc_ok   <= 1'b0;
      rx_err      <= 1'b0;
      rx_pkt_crc  <= '0;
      rx_overflow <= 1'b0;
    end else begin
      rx_eop <= 1'b0;
      if (rx_in_valid) begin
        case (rx_st)
          R_HUNT: if (hit0) rx_st <= R_M1;
          R_M1: begin
            if (hit1) begin
              rx_st       <= R_LEN;
              rx_overflow <= 1'b0;
            end else if (!hit0) begin
              rx_st <= R_HUNT;
            end
          end
          R_LEN: begin
            rx_len  <= rx_in_data;
            rx_left <= rx_in_data;
            crc_a   <= crc_step(crc_seed, rx_in_data);
            crc_z   <= crc_step(16'h0000, rx_in_data);
            rx_st   <= (rx_in_data == 8'd0) ? R_C1 : R_PAY;
          end
          R_PAY: begin
            crc_a   <= crc_step(crc_a, rx_in_data);
            crc_z   <= crc_step(crc_z, rx_in_data);
            rx_left <= rx_left - 1'b1;
            if (!rx_push) rx_overflow <= 1'b1;
            if (rx_left == 8'd1) rx_st <= R_C1;
          end
          R_C1: begin
            rx_hi <= rx_in_data;
            rx_st <= R_C2;
          end
          R_C2: begin
            rx_eop     <= 1'b1;
            rx_crc_ok  <= rx_match;
            rx_err     <= !rx_match || rx_overflow;
            rx_pkt_crc <= rx_got;
            rx_st      <= R_HUNT;
          end
          default: rx_st <= R_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp        <= '0;
      rx_rp        <= '0;
      rx_cnt       <= '0;
      rx_underflow <= 1'b0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt       <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      rx_underflow <= rx_rd_en && rx_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_push) rx_mem[rx_wp] <= rx_in_data;
  end
endmodule

// File: rtl/pkt_framer_chk.sv
`timescale 1ns/1ps
module pkt_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_empty,
  input logic       tx_done,
  input logic       tx_underflow,
  input logic       rx_eop,
  input logic       rx_err,
  input logic       rx_overflow,
  input logic       rx_underflow,
  input logic       rx_empty,
  input logic       rx_rd_en
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !tx_empty |=> tx_valid && $stable(tx_data)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !tx_valid); // R2
  AST_TX_UNDER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |-> $past(tx_empty)); // R7
  AST_RX_UNDER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underflow |-> $past(rx_empty && rx_rd_en)); // R13
  AST_OVF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop && rx_overflow |-> rx_err); // R12
  AST_EOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop |=> !rx_eop); // R10
endmodule

bind pkt_framer pkt_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_empty(tx_empty), .tx_done(tx_done),
  .tx_underflow(tx_underflow), .rx_eop(rx_eop), .rx_err(rx_err),
  .rx_overflow(rx_overflow), .rx_underflow(rx_underflow),
  .rx_empty(rx_empty), .rx_rd_en(rx_rd_en)
);

// File: tb/pkt_framer_tb.sv
`timescale 1ns/1ps
module pkt_framer_tb;
  localparam int DEPTH = 16;
  localparam int PRE_CNT = 2;
  localparam logic [7:0] PRE = 8'h55, M0 = 8'hB4, M1 = 8'h2D;
  localparam logic [15:0] SEED = 16'h1D0F;

  logic clk, rst_n;
  logic [15:0] crc_seed, ack_crc, rx_pkt_crc;
  logic tx_wr_en, tx_seed_zero, tx_go, ack_go, tx_ready;
  logic [7:0] tx_wr_data, tx_len, tx_data, rx_in_data, rx_rd_data, rx_len;
  logic tx_valid, tx_done, tx_empty, tx_half, tx_overflow, tx_underflow;
  logic rx_framing_en, rx_in_valid, rx_in_corr, rx_rd_en;
  logic rx_eop, rx_crc_ok, rx_err, rx_empty, rx_half, rx_overflow, rx_underflow;

  pkt_framer #(.DEPTH(DEPTH), .PRE_CNT(PRE_CNT), .PREAMBLE(PRE), .MARK0(M0), .MARK1(M1)) u_dut (
    .clk(clk), .rst_n(rst_n), .crc_seed(crc_seed), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_len(tx_len), .tx_seed_zero(tx_seed_zero), .tx_go(tx_go), .ack_go(ack_go), .ack_crc(ack_crc),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_done(tx_done),
    .tx_empty(tx_empty), .tx_half(tx_half), .tx_overflow(tx_overflow), .tx_underflow(tx_underflow),
    .rx_framing_en(rx_framing_en), .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
    .rx_in_corr(rx_in_corr), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_len(rx_len),
    .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok), .rx_err(rx_err), .rx_pkt_crc(rx_pkt_crc),
    .rx_empty(rx_empty), .rx_half(rx_half), .rx_overflow(rx_overflow), .rx_underflow(rx_underflow));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = r << 1;
      if (fb) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  function automatic logic [7:0] pl(input int i, input int len);
    return 8'(i * 13 + len * 3 + 5);
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  logic [7:0] cap [0:63];
  int ncap = 0, n_txund = 0, n_eop = 0;
  always @(negedge clk) begin
    if (tx_valid && tx_ready && ncap < 64) begin
      cap[ncap] = tx_data;
      ncap++;
    end
    if (tx_underflow) n_txund++;
    if (rx_eop) n_eop++;
  end

  logic [7:0] exq [0:63];
  int nexp;

  task automatic push_exp(input logic [7:0] b);
    exq[nexp] = b;
    nexp++;
  endtask

  task automatic cmp_stream(input string req);
    chk(ncap == nexp, {req, " byte count"}, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++)
      chk(cap[i] == exq[i], {req, " stream byte"}, cap[i], exq[i]);
  endtask

  // R2 R3 R4 R6 R7: send one data packet and compare the stream
  task automatic run_tx(input int len, input bit zero, input bit stall, input int nwrite,
                        input int start_idx, input bit both, input string req);
    int idx = start_idx;
    int c = 0;
    logic [15:0] cr;
    while (idx < nwrite && idx < DEPTH) begin
      tx_wr_en = 1'b1; tx_wr_data = pl(idx, len);
      cyc();
      idx++;
    end
    tx_wr_en = 1'b0;
    tx_len = 8'(len); tx_seed_zero = zero; ack_crc = 16'hA5A5;
    ncap = 0; n_txund = 0;
    tx_go = 1'b1; ack_go = both;
    cyc();
    tx_go = 1'b0; ack_go = 1'b0;
    while (!tx_done && c < 2000) begin
      tx_ready = stall ? (c % 3 != 2) : 1'b1;
      if (idx < nwrite && tx_half) begin
        tx_wr_en = 1'b1; tx_wr_data = pl(idx, len); idx++;
      end else tx_wr_en = 1'b0;
      cyc();
      c++;
    end
    tx_wr_en = 1'b0; tx_ready = 1'b1;
    nexp = 0;
    for (int i = 0; i < PRE_CNT; i++) push_exp(PRE);
    push_exp(M0); push_exp(M1); push_exp(8'(len));
    cr = zero ? 16'h0000 : SEED;
    cr = crc_b(cr, 8'(len));
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = (i < nwrite) ? pl(i, len) : 8'h00;
      push_exp(b);
      cr = crc_b(cr, b);
    end
    push_exp(cr[15:8]); push_exp(cr[7:0]);
    cmp_stream(req);
    chk(tx_done == 1'b1, {req, " R2 done pulse"}, tx_done, 1);
    chk(!tx_valid, {req, " R2 idle after packet"}, tx_valid, 0);
    chk(n_txund == ((len > nwrite) ? len - nwrite : 0), {req, " R7 underflow pulses"}, n_txund,
        (len > nwrite) ? len - nwrite : 0);
    chk(tx_empty, {req, " R7 buffer empty after"}, tx_empty, 1);
    cyc();
    chk(!tx_done && !tx_valid, {req, " R2 single done pulse"}, {tx_done, tx_valid}, 0);
  endtask

  task automatic test_ack();
    int c = 0;
    tx_wr_en = 1'b1; tx_wr_data = pl(0, 2); cyc();
    tx_wr_data = pl(1, 2); cyc();
    tx_wr_en = 1'b0;
    ncap = 0; tx_ready = 1'b1;
    ack_crc = 16'hBEEF; ack_go = 1'b1;
    cyc();
    ack_go = 1'b0;
    repeat (3) cyc();
    tx_go = 1'b1; tx_len = 8'd9;
    cyc();
    tx_go = 1'b0;
    while (!tx_done && c < 100) begin cyc(); c++; end
    nexp = 0;
    for (int i = 0; i < PRE_CNT; i++) push_exp(PRE);
    push_exp(M0); push_exp(M1); push_exp(8'hBE); push_exp(8'hEF);
    cmp_stream("R5 ack packet");
    repeat (2) cyc();
    chk(!tx_valid, "R6 tx_go during ack not kept", tx_valid, 0);
    chk(!tx_empty, "R5 buffer kept after ack", tx_empty, 0);
    run_tx(2, 1'b0, 1'b0, 2, 2, 1'b0, "R5 payload intact after ack");
  endtask

  task automatic test_tx_full();
    for (int i = 0; i < 17; i++) begin
      tx_wr_en = 1'b1; tx_wr_data = pl(i, 16);
      cyc();
      if (i == 7) chk(tx_half == 1'b1, "R7 half at DEPTH/2", tx_half, 1);
      if (i == 8) chk(tx_half == 1'b0, "R7 half clears above DEPTH/2", tx_half, 0);
      if (i == 15) chk(tx_overflow == 1'b0, "R7 no overflow when filling", tx_overflow, 0);
    end
    tx_wr_en = 1'b0;
    chk(tx_overflow == 1'b1, "R7 overflow pulse on write when full", tx_overflow, 1);
    cyc();
    chk(tx_overflow == 1'b0, "R7 overflow is a pulse", tx_overflow, 0);
    run_tx(16, 1'b0, 1'b0, 16, 16, 1'b0, "R7 full buffer sent, extra write dropped");
  endtask

  logic [7:0] fb [0:63];
  bit fcr [0:63];
  int fn;
  logic [7:0] rdq [0:63];
  int nrd;

  task automatic add(input logic [7:0] b, input bit c);
    fb[fn] = b; fcr[fn] = c; fn++;
  endtask

  task automatic feed(input bit drain);
    for (int i = 0; i < fn; i++) begin
      rx_in_valid = 1'b1; rx_in_data = fb[i]; rx_in_corr = fcr[i];
      rx_rd_en = drain && !rx_empty;
      if (rx_rd_en) begin rdq[nrd] = rx_rd_data; nrd++; end
      cyc();
    end
    rx_in_valid = 1'b0; rx_in_corr = 1'b0; rx_rd_en = 1'b0;
  endtask

  task automatic rd_rest();
    int g = 0;
    while (!rx_empty && g < 64) begin
      rx_rd_en = 1'b1; rdq[nrd] = rx_rd_data; nrd++;
      cyc();
      g++;
    end
    rx_rd_en = 1'b0;
  endtask

  // mode: 0 configured seed, 1 zero seed, 2 corrupted check
  task automatic run_rx(input int len, input int mode, input bit framed, input bit extra,
                        input bit drain, input string req);
    logic [15:0] cr;
    bit ovf;
    int held;
    rx_framing_en = framed; nrd = 0; fn = 0;
    for (int i = 0; i < PRE_CNT; i++) add(PRE, 1'b0);
    if (extra) begin
      if (framed) add(M0, 1'b1);
      else begin add(8'h05, 1'b1); add(8'h00, 1'b0); end
    end
    add(M0, 1'b1); add(M1, 1'b1); add(8'(len), 1'b0);
    cr = (mode == 1) ? 16'h0000 : SEED;
    cr = crc_b(cr, 8'(len));
    for (int i = 0; i < len; i++) begin
      add(pl(i, len), 1'b0);
      cr = crc_b(cr, pl(i, len));
    end
    if (mode == 2) cr = cr ^ 16'h0001;
    add(cr[15:8], 1'b0); add(cr[7:0], 1'b0);
    feed(drain);
    ovf = !drain && (len > DEPTH);
    chk(rx_eop == 1'b1, {req, " R10 eop after length plus two"}, rx_eop, 1);
    chk(rx_len == 8'(len), {req, " R10 length captured"}, rx_len, len);
    chk(rx_crc_ok == (mode != 2), {req, " R11 check result"}, rx_crc_ok, mode != 2);
    chk(rx_pkt_crc == cr, {req, " R11 received check"}, rx_pkt_crc, cr);
    chk(rx_overflow == ovf, {req, " R12 overflow flag"}, rx_overflow, ovf);
    chk(rx_err == ((mode == 2) || ovf), {req, " R12 error flag"}, rx_err, (mode == 2) || ovf);
    if (ovf) chk(rx_half == 1'b1, {req, " R13 half when full"}, rx_half, 1);
    cyc();
    chk(rx_eop == 1'b0, {req, " R10 eop is a pulse"}, rx_eop, 0);
    rd_rest();
    held = ovf ? DEPTH : len;
    chk(nrd == held, {req, " R13 bytes read"}, nrd, held);
    for (int i = 0; i < nrd && i < held; i++)
      chk(rdq[i] == pl(i, len), {req, " R13 payload byte"}, rdq[i], pl(i, len));
    chk(rx_empty && !rx_half, {req, " R13 empty after reads"}, {rx_empty, rx_half}, 2'b10);
  endtask

  task automatic test_rx_underflow();
    rx_rd_en = 1'b1;
    cyc();
    rx_rd_en = 1'b0;
    chk(rx_underflow == 1'b1, "R13 underflow on empty read", rx_underflow, 1);
    cyc();
    chk(rx_underflow == 1'b0, "R13 underflow is a pulse", rx_underflow, 0);
  endtask

  task automatic test_false_start();
    int e0 = n_eop;
    rx_framing_en = 1'b1; fn = 0;
    add(M0, 1'b0); add(8'h11, 1'b0); add(M1, 1'b0); add(8'h03, 1'b0);
    add(8'h01, 1'b0); add(8'h02, 1'b0); add(8'h03, 1'b0); add(8'h40, 1'b0); add(8'h41, 1'b0);
    feed(1'b0);
    repeat (2) cyc();
    chk(n_eop == e0, "R8 broken marker starts nothing", n_eop - e0, 0);
    chk(rx_empty == 1'b1, "R8 no payload taken after broken marker", rx_empty, 1);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; crc_seed = SEED; ack_crc = '0;
    tx_wr_en = 1'b0; tx_wr_data = '0; tx_len = '0; tx_seed_zero = 1'b0;
    tx_go = 1'b0; ack_go = 1'b0; tx_ready = 1'b1;
    rx_framing_en = 1'b1; rx_in_valid = 1'b0; rx_in_data = '0; rx_in_corr = 1'b0; rx_rd_en = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk(!tx_valid && !rx_eop && !rx_err && !rx_crc_ok && !rx_overflow, "R1 outputs low after reset",
        {tx_valid, rx_eop, rx_err, rx_crc_ok, rx_overflow}, 0);
    chk(tx_empty && tx_half && rx_empty, "R1 buffers empty after reset",
        {tx_empty, tx_half, rx_empty}, 3'b111);

    run_tx(4, 1'b0, 1'b0, 4, 0, 1'b0, "R2 R3 short packet");
    run_tx(5, 1'b1, 1'b1, 5, 0, 1'b0, "R3 R4 zero seed with stalls");
    run_tx(0, 1'b0, 1'b0, 0, 0, 1'b1, "R6 both starts, length zero");
    run_tx(20, 1'b0, 1'b1, 20, 0, 1'b0, "R7 refill during packet");
    run_tx(3, 1'b0, 1'b0, 1, 0, 1'b0, "R7 starved buffer pads");
    test_ack();
    test_tx_full();

    run_rx(3, 0, 1'b1, 1'b0, 1'b0, "R8 R11 framed, configured seed");
    run_rx(5, 1, 1'b1, 1'b1, 1'b0, "R8 R11 repeated marker, zero seed");
    run_rx(4, 2, 1'b1, 1'b0, 1'b0, "R11 corrupted check");
    run_rx(0, 0, 1'b1, 1'b0, 1'b0, "R10 length zero");
    test_false_start();
    run_rx(6, 0, 1'b0, 1'b1, 1'b0, "R9 correlation start");
    run_rx(18, 0, 1'b1, 1'b0, 1'b0, "R12 overflow without draining");
    test_rx_underflow();
    run_rx(24, 0, 1'b1, 1'b0, 1'b1, "R13 drained long packet");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule